// File: doc/BRIEF.md
# Two-Floor Lift Controller

This block is a Moore state machine that runs a lift between a lower and an upper floor. It watches a call button for each floor, an arrival sensor for each floor and a door-obstruction/open signal. From these it steps the car through waiting, shutting the door, climbing and descending. The current 3-bit state code is driven out, together with three command lines decoded from that code alone: motor up, motor down and door close.

The state code is chosen so that its bits carry meaning. The top bit marks that the car is no longer parked with the door open. The middle bit, together with the top bit, marks motion. The low bit tells which end of the shaft the car belongs to. Calls are not remembered: a call that is released before the controller acts on it is lost. An active-low clear parks the machine at the lower floor with the door open, at once and without a clock edge. The two spare codes fall back to the lower-floor wait state on the next edge.

Top module: `lift_ctrl`

## Requirements
- R1: While `clr_n` is low the state code is 000 and all three commands are low. The clear takes effect without waiting for a clock edge.
- R2: In the lower wait state (000), `call_hi`=1 moves the state to 100 on the next edge. With `call_hi`=0 the state stays 000, whatever `call_lo`, `at_lo`, `at_hi` and `door_open` are.
- R3: In the lower door-shutting state (100), `door_open`=1 returns the state to 000, and `door_open`=0 moves it to 110.
- R4: In the climbing state (110), the state stays 110 while `at_hi`=0, regardless of the other inputs. `at_hi`=1 moves it to 001.
- R5: In the upper wait state (001), `call_lo`=1 moves the state to 101. With `call_lo`=0 the state stays 001, whatever the other inputs are.
- R6: In the upper door-shutting state (101), `door_open`=1 returns the state to 001, and `door_open`=0 moves it to 111.
- R7: In the descending state (111), the state stays 111 while `at_lo`=0, regardless of the other inputs. `at_lo`=1 moves it to 000.
- R8: `motor_up` is high exactly when the state code is 110.
- R9: `motor_down` is high exactly when the state code is 111.
- R10: `door_close` is high exactly when the state code is 100 or 101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the state register |
| clr_n | input | 1 | Active-low asynchronous clear to the lower wait state |
| call_lo | input | 1 | Call for the lower floor |
| call_hi | input | 1 | Call for the upper floor |
| at_lo | input | 1 | Car has reached the lower floor |
| at_hi | input | 1 | Car has reached the upper floor |
| door_open | input | 1 | Door is held or sensed open |
| state_code | output | 3 | Current state code |
| motor_up | output | 1 | Drive the car upward |
| motor_down | output | 1 | Drive the car downward |
| door_close | output | 1 | Command the door to shut |

## Verification
The bench holds unrelated inputs high in every state, for example the lower call and both floor sensors while parked at the bottom. A controller that decoded the wrong input would then leave a wait state or a travel state too early. It reopens the door in both shutting states. A design that ignored the reopen would start the motor with the door open, and one that returned to the wrong floor's wait state would show the wrong low bit. It also drops the clear between clock edges while the car is climbing. A synchronous clear would leave the motor running until the next edge.

// File: rtl/lift_pkg.sv
package lift_pkg;

  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_WAIT_LO = 3'b000,
    ST_SHUT_LO = 3'b100,
    ST_CLIMB   = 3'b110,
    ST_WAIT_HI = 3'b001,
    ST_SHUT_HI = 3'b101,
    ST_DESCEND = 3'b111
  } lift_state_e;

  typedef struct packed {
    logic call_lo;
    logic call_hi;
    logic at_lo;
    logic at_hi;
    logic door_open;
  } lift_in_t;

  // Next state of the car as a function of the current code and inputs.
  function automatic lift_state_e lift_step(input logic [STATE_W-1:0] cur,
                                            input lift_in_t ins);
    lift_state_e nxt;
    case (cur)
      ST_WAIT_LO: nxt = ins.call_hi   ? ST_SHUT_LO : ST_WAIT_LO;
      ST_SHUT_LO: nxt = ins.door_open ? ST_WAIT_LO : ST_CLIMB;
      ST_CLIMB:   nxt = ins.at_hi     ? ST_WAIT_HI : ST_CLIMB;
      ST_WAIT_HI: nxt = ins.call_lo   ? ST_SHUT_HI : ST_WAIT_HI;
      ST_SHUT_HI: nxt = ins.door_open ? ST_WAIT_HI : ST_DESCEND;
      ST_DESCEND: nxt = ins.at_lo     ? ST_WAIT_LO : ST_DESCEND;
      default:    nxt = ST_WAIT_LO;
    endcase
    return nxt;
  endfunction

  // Output decodes read only the code bits.
  function automatic logic dec_up(input logic [STATE_W-1:0] s);
    return s[2] & s[1] & ~s[0];
  endfunction

  function automatic logic dec_down(input logic [STATE_W-1:0] s);
    return s[2] & s[1] & s[0];
  endfunction

  function automatic logic dec_shut(input logic [STATE_W-1:0] s);
    return s[2] & ~s[1];
  endfunction

endpackage

// File: rtl/lift_next_logic.sv
module lift_next_logic
  import lift_pkg::*;
(
  input  logic [STATE_W-1:0] cur,
  input  lift_in_t           ins,
  output lift_state_e        nxt,
  output logic               depart,
  output logic               arrive
);
  always_comb begin
    nxt = lift_step(cur, ins);
  end

  // Named events for the checker: leaving a door-shutting state into motion,
  // and leaving a motion state into a wait state.
  assign depart = (~cur[1] & cur[2]) & nxt[1];
  assign arrive = (cur[2] & cur[1]) & ~nxt[2];
endmodule

// File: rtl/lift_state_reg.sv
module lift_state_reg
  import lift_pkg::*;
#(
  parameter logic [STATE_W-1:0] RESET_CODE = ST_WAIT_LO
) (
  input  logic               clk,
  input  logic               clr_n,
  input  logic [STATE_W-1:0] nxt,
  output logic [STATE_W-1:0] cur
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) cur <= RESET_CODE;
    else        cur <= nxt;
  end
endmodule

// File: rtl/lift_cmd_decode.sv
module lift_cmd_decode
  import lift_pkg::*;
(
  input  logic [STATE_W-1:0] cur,
  output logic               motor_up,
  output logic               motor_down,
  output logic               door_close
);
  assign motor_up   = dec_up(cur);
  assign motor_down = dec_down(cur);
  assign door_close = dec_shut(cur);
endmodule

// File: rtl/lift_ctrl.sv
module lift_ctrl
  import lift_pkg::*;
(
  input  logic         clk,
  input  logic         clr_n,
  input  logic         call_lo,
  input  logic         call_hi,
  input  logic         at_lo,
  input  logic         at_hi,
  input  logic         door_open,
  output logic [2:0]   state_code,
  output logic         motor_up,
  output logic         motor_down,
  output logic         door_close
);
  lift_in_t           ins;
  lift_state_e        nxt_state;
  logic [STATE_W-1:0] cur_state;
  logic               ev_depart;
  logic               ev_arrive;

  assign ins = '{call_lo: call_lo, call_hi: call_hi, at_lo: at_lo,
                 at_hi: at_hi, door_open: door_open};

  lift_next_logic u_next (
    .cur    (cur_state),
    .ins    (ins),
    .nxt    (nxt_state),
    .depart (ev_depart),
    .arrive (ev_arrive)
  );

  lift_state_reg #(.RESET_CODE(ST_WAIT_LO)) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .nxt   (nxt_state),
    .cur   (cur_state)
  );

  lift_cmd_decode u_dec (
    .cur        (cur_state),
    .motor_up   (motor_up),
    .motor_down (motor_down),
    .door_close (door_close)
  );

  assign state_code = cur_state;
endmodule

// File: rtl/lift_ctrl_chk.sv
module lift_ctrl_chk (
  input logic       clk,
  input logic       clr_n,
  input logic       call_lo,
  input logic       call_hi,
  input logic       at_lo,
  input logic       at_hi,
  input logic       door_open,
  input logic [2:0] state_code,
  input logic       motor_up,
  input logic       motor_down,
  input logic       door_close,
  input logic       ev_depart,
  input logic       ev_arrive
);
  assert_wait_lo_hold_R2: assert property (@(posedge clk) disable iff (!clr_n)
    (state_code == 3'b000 && !call_hi) |=> state_code == 3'b000);
  assert_wait_lo_go_R2: assert property (@(posedge clk) disable iff (!clr_n)
    (state_code == 3'b000 && call_hi) |=> state_code == 3'b100);
  assert_shut_lo_reopen_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (state_code == 3'b100 && door_open) |=> state_code == 3'b000);
  assert_shut_lo_go_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (state_code == 3'b100 && !door_open) |=> state_code == 3'b110);
  assert_climb_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (state_code == 3'b110) |=> (state_code == (at_hi ? 3'b110 : 3'b110) ||
                                state_code == 3'b001));
  assert_climb_hold_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (state_code == 3'b110 && !at_hi) |=> state_code == 3'b110);
  assert_wait_hi_R5: assert property (@(posedge clk) disable iff (!clr_n)
    (state_code == 3'b001 && call_lo) |=> state_code == 3'b101);
  assert_shut_hi_R6: assert property (@(posedge clk) disable iff (!clr_n)
    (state_code == 3'b101 && !door_open) |=> state_code == 3'b111);
  assert_descend_R7: assert property (@(posedge clk) disable iff (!clr_n)
    (state_code == 3'b111 && at_lo) |=> state_code == 3'b000);
  assert_up_code_R8: assert property (@(posedge clk) disable iff (!clr_n)
    motor_up |-> state_code == 3'b110);
  assert_down_code_R9: assert property (@(posedge clk) disable iff (!clr_n)
    motor_down |-> state_code == 3'b111);
  assert_shut_code_R10: assert property (@(posedge clk) disable iff (!clr_n)
    door_close |-> (state_code == 3'b100 || state_code == 3'b101));
  // R8 R9 R10: at most one command at a time.
  assert_cmds_excl_R10: assert property (@(posedge clk) disable iff (!clr_n)
    $onehot0({motor_up, motor_down, door_close}));
  // R3 R6: the motor only starts from a door-shutting state with door shut.
  assert_depart_shut_R3: assert property (@(posedge clk) disable iff (!clr_n)
    ev_depart |-> (door_close && !door_open));
  // R4 R7: arrival only ends a motion state.
  assert_arrive_motion_R7: assert property (@(posedge clk) disable iff (!clr_n)
    ev_arrive |-> (motor_up || motor_down));
endmodule

bind lift_ctrl lift_ctrl_chk u_chk (
  .clk        (clk),
  .clr_n      (clr_n),
  .call_lo    (call_lo),
  .call_hi    (call_hi),
  .at_lo      (at_lo),
  .at_hi      (at_hi),
  .door_open  (door_open),
  .state_code (state_code),
  .motor_up   (motor_up),
  .motor_down (motor_down),
  .door_close (door_close),
  .ev_depart  (ev_depart),
  .ev_arrive  (ev_arrive)
);

// File: tb/lift_ctrl_bench.sv
module lift_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       call_lo = 1'b0, call_hi = 1'b0, at_lo = 1'b0, at_hi = 1'b0;
  logic       door_open = 1'b0;
  logic [2:0] state_code;
  logic       motor_up, motor_down, door_close;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lift_ctrl u_lift_ctrl (
    .clk(clk), .clr_n(clr_n), .call_lo(call_lo), .call_hi(call_hi),
    .at_lo(at_lo), .at_hi(at_hi), .door_open(door_open),
    .state_code(state_code), .motor_up(motor_up),
    .motor_down(motor_down), .door_close(door_close)
  );

  // Compare code and the commands expected for that code (R8, R9, R10).
  task automatic check(input logic [2:0] exp, input string req);
    logic eu, ed, ec;
    eu = (exp == 3'b110);
    ed = (exp == 3'b111);
    ec = (exp == 3'b100) || (exp == 3'b101);
    checks++;
    if (state_code !== exp) begin
      errors++;
      $display("FAIL %s: state=%b expected %b", req, state_code, exp);
    end
    checks++;
    if ({motor_up, motor_down, door_close} !== {eu, ed, ec}) begin
      errors++;
      $display("FAIL R8/R9/R10 (%s): up,down,close=%b expected %b",
               req, {motor_up, motor_down, door_close}, {eu, ed, ec});
    end
  endtask

  // Drive inputs away from the edge, clock once, sample just after.
  task automatic step(input logic cl, input logic ch, input logic al,
                      input logic ah, input logic op);
    @(negedge clk);
    call_lo = cl; call_hi = ch; at_lo = al; at_hi = ah; door_open = op;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    clr_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check(3'b000, "R1");
    @(negedge clk);
    clr_n = 1'b1;
  endtask

  task automatic t_wait_lo;
    step(1, 0, 1, 1, 1);
    check(3'b000, "R2");
    step(0, 1, 0, 0, 0);
    check(3'b100, "R2");
  endtask

  task automatic t_shut_lo;
    step(0, 0, 0, 0, 1);
    check(3'b000, "R3");
    step(0, 1, 0, 0, 0);
    check(3'b100, "R3");
    step(1, 1, 1, 0, 0);
    check(3'b110, "R3");
  endtask

  task automatic t_climb;
    step(1, 1, 1, 0, 1);
    check(3'b110, "R4");
    step(0, 0, 0, 1, 0);
    check(3'b001, "R4");
  endtask

  task automatic t_wait_hi;
    step(0, 1, 1, 1, 1);
    check(3'b001, "R5");
    step(1, 0, 0, 0, 0);
    check(3'b101, "R5");
  endtask

  task automatic t_shut_hi;
    step(0, 0, 0, 0, 1);
    check(3'b001, "R6");
    step(1, 0, 0, 0, 0);
    check(3'b101, "R6");
    step(1, 1, 0, 1, 0);
    check(3'b111, "R6");
  endtask

  task automatic t_descend;
    step(1, 1, 0, 1, 1);
    check(3'b111, "R7");
    step(0, 0, 1, 0, 0);
    check(3'b000, "R7");
  endtask

  task automatic t_async_clear;
    step(0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    check(3'b110, "R8");
    @(negedge clk);
    #2;
    clr_n = 1'b0;
    #1;
    check(3'b000, "R1");
    @(negedge clk);
    clr_n = 1'b1;
    step(0, 0, 0, 0, 0);
    check(3'b000, "R1");
  endtask

  initial begin
    t_reset();
    t_wait_lo();
    t_shut_lo();
    t_climb();
    t_wait_hi();
    t_shut_hi();
    t_descend();
    t_async_clear();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule